// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block keeps the privileged control state that a simple in-order core needs to hand control to fault-handling software. When the pipeline raises an exception request, the controller records the program counter of the faulting instruction and a cause code. For a page fault it also records the faulting virtual address. In the same cycle it presents a redirect to a fixed handler address, and it clears an interrupt-enable status bit so that handler code runs without being disturbed.

A return strobe sends fetch back to the saved program counter and sets the enable bit again. A fault that arrives while the enable bit is clear is a nested fault. The saved state stays as it is, and fetch goes to a separate double-fault handler. A fault taken inside the double-fault handler raises a shutdown flag that stays set until reset. Software reads the saved state through a select-driven combinational read port.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, the saved PC, saved cause and saved bad address are zero, shutdown is low, the nesting level is 0 and the enable bit is 1. The status word reads as 0x1. Its layout is bit 0 enable, bits 2:1 nesting level (0 normal, 1 handler, 2 double-fault) and bit 3 shutdown.
- R2: An exception request while the enable bit is 1 drives redirect_valid high in the same cycle, with redirect_pc = PRIMARY_VEC (default 0x80000180).
- R3: On an accepted primary exception, the saved PC takes exc_pc and the saved cause takes exc_cause. The saved bad address takes exc_badaddr only when the cause is 16 (page fault). For any other cause the saved bad address keeps its value.
- R4: Taking a primary exception clears the enable bit and sets the nesting level to 1. The enable bit becomes 1 again only through a return.
- R5: A return strobe with no exception request in the same cycle drives redirect_valid with redirect_pc equal to the saved PC. Afterwards the enable bit is 1 and the level is 0. This applies from level 1 and from level 2.
- R6: An exception request while the enable bit is 0 and the level is 1 redirects to DOUBLE_VEC (default 0x80000200), moves the level to 2, and leaves the saved PC and saved cause unchanged.
- R7: An exception request at level 2 gives no redirect and sets shutdown from the next cycle on. Shutdown clears only on reset.
- R8: While shutdown is high, exception and return strobes are ignored: redirect_valid stays low and the saved state does not change.
- R9: When an exception request and a return strobe arrive in the same cycle, the exception wins and the return has no effect.
- R10: The read port is combinational. rd_sel values are 0 saved PC, 1 saved cause (zero-extended), 2 saved bad address, 3 status word. Any other value reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request from the pipeline |
| exc_cause | input | CAUSE_W (5) | Cause code of the request |
| exc_pc | input | XLEN (32) | PC of the faulting instruction |
| exc_badaddr | input | XLEN (32) | Faulting virtual address |
| eret | input | 1 | Return-from-exception strobe |
| rd_sel | input | SEL_W (3) | Control register read select |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | XLEN (32) | Redirect target |
| rd_data | output | XLEN (32) | Selected control register value |
| shutdown | output | 1 | Permanent halt flag |

## Verification
A corrupted nesting level or enable bit shows at the ports on the next request. The controller sends that request to the wrong vector, or fails to redirect it, in the same cycle the request arrives. The status word also shows the bad state one cycle after the transition that caused it. An unwanted overwrite of the saved PC or cause only shows up when software reads it or returns. For that reason the bench reads every saved register after each nested fault and ends each handler with a return, checking the target address.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [1:0] {
      LVL_NORMAL  = 2'd0,
      LVL_HANDLER = 2'd1,
      LVL_DOUBLE  = 2'd2
   } lvl_e;

   localparam int unsigned CAUSE_BITS = 5;
   localparam logic [CAUSE_BITS-1:0] CAUSE_INTERRUPT  = 5'd0;
   localparam logic [CAUSE_BITS-1:0] CAUSE_ADDR_LOAD  = 5'd4;
   localparam logic [CAUSE_BITS-1:0] CAUSE_ADDR_STORE = 5'd5;
   localparam logic [CAUSE_BITS-1:0] CAUSE_ILLEGAL    = 5'd10;
   localparam logic [CAUSE_BITS-1:0] CAUSE_OVERFLOW   = 5'd12;
   localparam logic [CAUSE_BITS-1:0] CAUSE_DIV_ZERO   = 5'd13;
   localparam logic [CAUSE_BITS-1:0] CAUSE_PAGE_FAULT = 5'd16;
   localparam logic [CAUSE_BITS-1:0] CAUSE_PROTECT    = 5'd17;

   localparam logic [2:0] SEL_EPC     = 3'd0;
   localparam logic [2:0] SEL_CAUSE   = 3'd1;
   localparam logic [2:0] SEL_BADADDR = 3'd2;
   localparam logic [2:0] SEL_STATUS  = 3'd3;
endpackage

// File: rtl/exc_nest_ctrl.sv
module exc_nest_ctrl
   import exc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic exc_req,
   input  logic eret,
   output logic ie,
   output lvl_e level,
   output logic halted,
   output logic take_primary,
   output logic take_double,
   output logic take_return
);
   logic escalate;

   always_comb begin
      take_primary = !halted && exc_req && ie;
      take_double  = !halted && exc_req && !ie && (level == LVL_HANDLER);
      escalate     = !halted && exc_req && !ie && (level == LVL_DOUBLE);
      take_return  = !halted && eret && !exc_req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie     <= 1'b1;
         level  <= LVL_NORMAL;
         halted <= 1'b0;
      end else if (take_primary) begin
         ie    <= 1'b0;
         level <= LVL_HANDLER;
      end else if (take_double) begin
         level <= LVL_DOUBLE;
      end else if (escalate) begin
         halted <= 1'b1;
      end else if (take_return) begin
         ie    <= 1'b1;
         level <= LVL_NORMAL;
      end
   end

   a_r4_entry_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
      take_primary |=> (!ie && level == LVL_HANDLER));
   a_r4_enable_only_by_return: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie && !take_return) |=> !ie);
   a_r7_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   a_r7_escalate_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && level == LVL_DOUBLE) |=> halted);
endmodule

// File: rtl/exc_capture.sv
module exc_capture #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 5,
   parameter logic [CAUSE_W-1:0] PF_CODE = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [CAUSE_W-1:0] cause_in,
   input  logic [XLEN-1:0]    pc_in,
   input  logic [XLEN-1:0]    badaddr_in,
   output logic [XLEN-1:0]    epc_q,
   output logic [CAUSE_W-1:0] cause_q,
   output logic [XLEN-1:0]    badvaddr_q
);
   logic is_pf;
   assign is_pf = (cause_in == PF_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q      <= '0;
         cause_q    <= '0;
         badvaddr_q <= '0;
      end else if (load) begin
         epc_q   <= pc_in;
         cause_q <= cause_in;
         if (is_pf) badvaddr_q <= badaddr_in;
      end
   end

   a_r6_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(epc_q) && $stable(cause_q) && $stable(badvaddr_q)));
   a_r3_badaddr_only_pf: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !is_pf) |=> $stable(badvaddr_q));
   a_r3_epc_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (epc_q == $past(pc_in)));
endmodule

// File: rtl/exc_csr_read.sv
module exc_csr_read #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 5,
   parameter int unsigned SEL_W   = 3
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic [XLEN-1:0]    epc,
   input  logic [CAUSE_W-1:0] cause,
   input  logic [XLEN-1:0]    badvaddr,
   input  logic [3:0]         status,
   output logic [XLEN-1:0]    data
);
   always_comb begin
      data = '0;
      case (sel)
         SEL_W'(exc_pkg::SEL_EPC):     data = epc;
         SEL_W'(exc_pkg::SEL_CAUSE):   data = XLEN'(cause);
         SEL_W'(exc_pkg::SEL_BADADDR): data = badvaddr;
         SEL_W'(exc_pkg::SEL_STATUS):  data = XLEN'(status);
         default:                      data = '0;
      endcase
   end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
   import exc_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 5,
   parameter int unsigned SEL_W   = 3,
   parameter logic [XLEN-1:0] PRIMARY_VEC = 32'h8000_0180,
   parameter logic [XLEN-1:0] DOUBLE_VEC  = 32'h8000_0200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_req,
   input  logic [CAUSE_W-1:0] exc_cause,
   input  logic [XLEN-1:0]    exc_pc,
   input  logic [XLEN-1:0]    exc_badaddr,
   input  logic               eret,
   input  logic [SEL_W-1:0]   rd_sel,
   output logic               redirect_valid,
   output logic [XLEN-1:0]    redirect_pc,
   output logic [XLEN-1:0]    rd_data,
   output logic               shutdown
);
   localparam logic [CAUSE_W-1:0] PF_CODE = CAUSE_W'(CAUSE_PAGE_FAULT);

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("exc_ctrl: XLEN must be at least 32");
      end
      if (CAUSE_W < CAUSE_BITS) begin : g_bad_cause
         $error("exc_ctrl: CAUSE_W too narrow for cause codes");
      end
      if (SEL_W < 2) begin : g_bad_sel
         $error("exc_ctrl: SEL_W must cover four registers");
      end
   endgenerate

   logic ie, halted, take_primary, take_double, take_return;
   lvl_e level;
   logic [XLEN-1:0]    epc_q, badvaddr_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [3:0]         status_w;

   exc_nest_ctrl u_nest (
      .clk          (clk),
      .rst_n        (rst_n),
      .exc_req      (exc_req),
      .eret         (eret),
      .ie           (ie),
      .level        (level),
      .halted       (halted),
      .take_primary (take_primary),
      .take_double  (take_double),
      .take_return  (take_return)
   );

   exc_capture #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .PF_CODE(PF_CODE)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (take_primary),
      .cause_in   (exc_cause),
      .pc_in      (exc_pc),
      .badaddr_in (exc_badaddr),
      .epc_q      (epc_q),
      .cause_q    (cause_q),
      .badvaddr_q (badvaddr_q)
   );

   assign status_w = {halted, level, ie};

   exc_csr_read #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .SEL_W(SEL_W)) u_rd (
      .sel      (rd_sel),
      .epc      (epc_q),
      .cause    (cause_q),
      .badvaddr (badvaddr_q),
      .status   (status_w),
      .data     (rd_data)
   );

   always_comb begin
      redirect_valid = take_primary | take_double | take_return;
      redirect_pc    = '0;
      if (take_primary)     redirect_pc = PRIMARY_VEC;
      else if (take_double) redirect_pc = DOUBLE_VEC;
      else if (take_return) redirect_pc = epc_q;
   end

   assign shutdown = halted;

   a_r8_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> !redirect_valid);
   a_r6_nested_goes_double: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !ie && level == LVL_HANDLER && !shutdown) |-> (redirect_valid && redirect_pc == DOUBLE_VEC));
   a_r9_exception_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && eret && ie) |-> (redirect_pc == PRIMARY_VEC));
   a_r2_primary_target: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && level == LVL_NORMAL && !shutdown) |-> (redirect_valid && redirect_pc == PRIMARY_VEC));
endmodule

// File: tb/exc_ctrl_test.sv
module exc_ctrl_test;
   localparam int PERIOD = 10;
   localparam logic [31:0] PVEC = 32'h8000_0180;
   localparam logic [31:0] DVEC = 32'h8000_0200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic exc_req = 1'b0;
   logic [4:0] exc_cause = '0;
   logic [31:0] exc_pc = '0;
   logic [31:0] exc_badaddr = '0;
   logic eret = 1'b0;
   logic [2:0] rd_sel = '0;
   logic redirect_valid, shutdown;
   logic [31:0] redirect_pc, rd_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   exc_ctrl uut (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
      .exc_pc(exc_pc), .exc_badaddr(exc_badaddr), .eret(eret), .rd_sel(rd_sel),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .rd_data(rd_data), .shutdown(shutdown)
   );

   always #(PERIOD/2) clk = ~clk;

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic read_reg(input logic [2:0] sel, output logic [31:0] val);
      rd_sel = sel;
      #1;
      val = rd_data;
   endtask

   task automatic check_regs(input string req, input logic [31:0] e_epc, input logic [31:0] e_cause,
                             input logic [31:0] e_bad, input logic [31:0] e_status);
      logic [31:0] v;
      read_reg(3'd0, v); check(req, "epc", v, e_epc);
      read_reg(3'd1, v); check(req, "cause", v, e_cause);
      read_reg(3'd2, v); check(req, "badvaddr", v, e_bad);
      read_reg(3'd3, v); check(req, "status", v, e_status);
   endtask

   task automatic pulse(input string req, input logic rq, input logic rt, input logic [4:0] c,
                        input logic [31:0] pc, input logic [31:0] bad,
                        input logic e_valid, input logic [31:0] e_pc);
      @(negedge clk);
      exc_req = rq; eret = rt; exc_cause = c; exc_pc = pc; exc_badaddr = bad;
      #2;
      check(req, "redirect_valid", 32'(redirect_valid), 32'(e_valid));
      if (e_valid) check(req, "redirect_pc", redirect_pc, e_pc);
      @(posedge clk);
      #1;
      exc_req = 1'b0; eret = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check("R1", "shutdown", 32'(shutdown), 32'd0);
      check("R1", "redirect_valid", 32'(redirect_valid), 32'd0);
      check_regs("R1", 32'h0, 32'h0, 32'h0, 32'h1);
   endtask

   task automatic t_primary_and_return();
      pulse("R2", 1'b1, 1'b0, 5'd12, 32'h0040_0100, 32'h0000_dead, 1'b1, PVEC);
      check_regs("R3", 32'h0040_0100, 32'd12, 32'h0, 32'h2);
      pulse("R5", 1'b0, 1'b1, 5'd0, 32'h0, 32'h0, 1'b1, 32'h0040_0100);
      check_regs("R4", 32'h0040_0100, 32'd12, 32'h0, 32'h1);
   endtask

   task automatic t_page_fault();
      pulse("R2", 1'b1, 1'b0, 5'd16, 32'h0040_0200, 32'h1234_5000, 1'b1, PVEC);
      check_regs("R3", 32'h0040_0200, 32'd16, 32'h1234_5000, 32'h2);
      pulse("R5", 1'b0, 1'b1, 5'd0, 32'h0, 32'h0, 1'b1, 32'h0040_0200);
      pulse("R3", 1'b1, 1'b0, 5'd17, 32'h0040_0300, 32'h5555_0000, 1'b1, PVEC);
      check_regs("R3", 32'h0040_0300, 32'd17, 32'h1234_5000, 32'h2);
   endtask

   task automatic t_double_and_return();
      pulse("R6", 1'b1, 1'b0, 5'd10, 32'h8000_0190, 32'h0, 1'b1, DVEC);
      check_regs("R6", 32'h0040_0300, 32'd17, 32'h1234_5000, 32'h4);
      pulse("R5", 1'b0, 1'b1, 5'd0, 32'h0, 32'h0, 1'b1, 32'h0040_0300);
      check_regs("R5", 32'h0040_0300, 32'd17, 32'h1234_5000, 32'h1);
   endtask

   task automatic t_simultaneous();
      pulse("R9", 1'b1, 1'b1, 5'd13, 32'h0040_0400, 32'h0, 1'b1, PVEC);
      check_regs("R9", 32'h0040_0400, 32'd13, 32'h1234_5000, 32'h2);
   endtask

   task automatic t_triple();
      pulse("R6", 1'b1, 1'b0, 5'd4, 32'h8000_0184, 32'h0, 1'b1, DVEC);
      pulse("R7", 1'b1, 1'b0, 5'd5, 32'h8000_0204, 32'h0, 1'b0, 32'h0);
      check("R7", "shutdown", 32'(shutdown), 32'd1);
      pulse("R8", 1'b0, 1'b1, 5'd0, 32'h0, 32'h0, 1'b0, 32'h0);
      pulse("R8", 1'b1, 1'b0, 5'd16, 32'h0000_0888, 32'h0000_9999, 1'b0, 32'h0);
      check("R7", "shutdown held", 32'(shutdown), 32'd1);
      check_regs("R8", 32'h0040_0400, 32'd13, 32'h1234_5000, 32'hc);
   endtask

   task automatic t_select_default();
      logic [31:0] v;
      for (int s = 4; s < 8; s++) begin
         read_reg(3'(s), v);
         check("R10", "unmapped select", v, 32'h0);
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_primary_and_return();
      t_page_fault();
      t_double_and_return();
      t_simultaneous();
      t_triple();
      t_select_default();
      t_reset();
      pulse("R2", 1'b1, 1'b0, 5'd0, 32'h0000_0040, 32'h0, 1'b1, PVEC);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule